// File: doc/BRIEF.md
# Prioritized Interrupt Pending Selector

This block decides, for one hart, whether an interrupt should be taken now and which one. Each of the interrupt sources carries a pending bit, a per-source enable bit and a routing bit that says whether the source is handed down to the supervisor level or stays with machine level. The block combines these per-source bits with a global enable for each target level. That global enable depends on the privilege the hart is running at and on the global interrupt-enable bit of that level.

All sources that pass these gates are candidates. The candidate with the lowest index wins, and its index is reported as the cause number with a valid flag. With the default configuration the result is registered: the outputs show the decision for the inputs present at the previous rising clock edge. A parameter removes the register so the result follows the inputs combinationally. Trap entry and any virtualisation-level routing are handled elsewhere.

Top module: `intr_select`

## Requirements
- R1: A source can win only if both its pending bit and its enable bit are 1. A source with only one of the two bits set never makes the valid output 1.
- R2: The machine-level global enable is on when the privilege is below machine (value less than 3). It is also on when the privilege is machine and the machine enable input `m_gie_i` is 1.
- R3: The supervisor-level global enable is on when the privilege is user (0). It is also on when the privilege is supervisor (1) and the supervisor enable input `s_gie_i` is 1.
- R4: A source whose routing bit in `deleg_i` is 0 is allowed only while the machine-level global enable is on.
- R5: A source whose routing bit in `deleg_i` is 1 is allowed only while the supervisor-level global enable is on. This holds even when the hart runs at machine level with `s_gie_i` set.
- R6: When several allowed candidates exist, the cause output is the lowest bit index among them. This equals the count of trailing zeros of the allowed vector.
- R7: When no allowed candidate exists, the valid output is 0 and the cause output is 0.
- R8: With the default `REG_OUT`=1, the outputs change only at a rising clock edge. They reflect the inputs sampled at that edge.
- R9: A synchronous active-high reset clears the valid output and the cause output at the next rising edge.
- R10: Privilege is encoded on 2 bits: 0 is user, 1 is supervisor and 3 is machine. The unused value 2 is compared numerically, so machine-level sources are enabled and supervisor-level sources are blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | NSRC (32) | Pending bit per source |
| ena_i | input | NSRC (32) | Enable bit per source |
| deleg_i | input | NSRC (32) | Routing bit per source, 1 = supervisor target |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| irq_valid_o | output | 1 | An interrupt should be taken |
| irq_cause_o | output | CW (5) | Index of the winning source, 0 when not valid |

## Verification
The bench drives delegated and undelegated candidates together at machine level with the supervisor enable set. A design that let the supervisor enable gate work at machine level would report the delegated source instead of the undelegated one. It runs privilege user with every global enable cleared, where a design that required the enable bit below the target level would report nothing. It also uses the unused privilege value 2, which separates a numeric comparison from an equality-based decode. Dense vectors with bits at both ends, including source 31 alone, expose priority encoders that search from the wrong end or truncate the index. A check just before the clock edge catches an output that leaks through combinationally.

// File: rtl/intr_select_pkg.sv
package intr_select_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    // Machine-level targets: open below machine, or at machine with its enable.
    function automatic logic mach_level_open(priv_e p, logic gie);
        return (p < PRIV_MACH) || ((p == PRIV_MACH) && gie);
    endfunction

    // Supervisor-level targets: open below supervisor, or at supervisor with its enable.
    function automatic logic super_level_open(priv_e p, logic gie);
        return (p < PRIV_SUPER) || ((p == PRIV_SUPER) && gie);
    endfunction

endpackage

// File: rtl/intr_gate.sv
module intr_gate
    import intr_select_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] ena_i,
    input  logic [NSRC-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            m_gie_i,
    input  logic            s_gie_i,
    output logic [NSRC-1:0] cand_o
);

    logic m_open;
    logic s_open;

    always_comb begin
        m_open = mach_level_open(priv_e'(priv_i), m_gie_i);
        s_open = super_level_open(priv_e'(priv_i), s_gie_i);
    end

    // One gate per source: local pending/enable, then routing to a level.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic local_hit;
        logic level_open;
        always_comb begin
            local_hit  = pend_i[g] & ena_i[g];
            level_open = deleg_i[g] ? s_open : m_open;
            cand_o[g]  = local_hit & level_open;
        end
    end

endmodule

// File: rtl/intr_lowest_first.sv
module intr_lowest_first #(
    parameter int NSRC = 32,
    localparam int CW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] vec_i,
    output logic            any_o,
    output logic [CW-1:0]   idx_o
);

    // Scan from the top down so the last hit written is the lowest index.
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = CW'(i);
            end
        end
    end

endmodule

// File: rtl/intr_select.sv
module intr_select
    import intr_select_pkg::*;
#(
    parameter int NSRC    = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int CW     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] ena_i,
    input  logic [NSRC-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            m_gie_i,
    input  logic            s_gie_i,
    output logic            irq_valid_o,
    output logic [CW-1:0]   irq_cause_o
);

    typedef struct packed {
        logic          valid;
        logic [CW-1:0] cause;
    } pick_t;

    logic [NSRC-1:0] cand;
    logic            any_hit;
    logic [CW-1:0]   win_idx;
    pick_t           pick_d;
    pick_t           pick_q;

    intr_gate #(.NSRC(NSRC)) u_gate (
        .pend_i  (pend_i),
        .ena_i   (ena_i),
        .deleg_i (deleg_i),
        .priv_i  (priv_i),
        .m_gie_i (m_gie_i),
        .s_gie_i (s_gie_i),
        .cand_o  (cand)
    );

    intr_lowest_first #(.NSRC(NSRC)) u_pick (
        .vec_i (cand),
        .any_o (any_hit),
        .idx_o (win_idx)
    );

    always_comb begin
        pick_d.valid = any_hit;
        pick_d.cause = any_hit ? win_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pick_q <= '0;
        end else begin
            pick_q <= pick_d;
        end
    end

    if (REG_OUT) begin : g_reg
        assign irq_valid_o = pick_q.valid;
        assign irq_cause_o = pick_q.cause;
    end else begin : g_comb
        assign irq_valid_o = pick_d.valid;
        assign irq_cause_o = pick_d.cause;
    end

endmodule

// File: rtl/intr_select_chk.sv
module intr_select_chk #(
    parameter int NSRC    = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int CW     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] pend_i,
    input logic [NSRC-1:0] ena_i,
    input logic [NSRC-1:0] deleg_i,
    input logic [1:0]      priv_i,
    input logic            m_gie_i,
    input logic            s_gie_i,
    input logic            irq_valid_o,
    input logic [CW-1:0]   irq_cause_o
);

    if (REG_OUT) begin : g_seq
        logic [NSRC-1:0] p_s, e_s, d_s;
        logic            m_s, s_s, rst_s;
        logic [NSRC-1:0] gate_s;
        logic [NSRC-1:0] below_win;

        always_ff @(posedge clk) begin
            p_s   <= pend_i;
            e_s   <= ena_i;
            d_s   <= deleg_i;
            m_s   <= (priv_i != 2'b11) || m_gie_i;
            s_s   <= (priv_i == 2'b00) || ((priv_i == 2'b01) && s_gie_i);
            rst_s <= rst;
        end

        always_comb begin
            gate_s    = (d_s & {NSRC{s_s}}) | (~d_s & {NSRC{m_s}});
            below_win = (NSRC'(1) << irq_cause_o) - NSRC'(1);
        end

        // R1
        winner_is_candidate_chk: assert property (@(posedge clk) disable iff (rst)
            (!rst_s && irq_valid_o) |-> (p_s[irq_cause_o] && e_s[irq_cause_o]));

        // R4
        winner_routing_chk: assert property (@(posedge clk) disable iff (rst)
            (!rst_s && irq_valid_o) |-> (d_s[irq_cause_o] ? s_s : m_s));

        // R6
        no_lower_winner_chk: assert property (@(posedge clk) disable iff (rst)
            (!rst_s && irq_valid_o) |-> ((p_s & e_s & gate_s & below_win) == '0));

        // R7
        idle_when_none_chk: assert property (@(posedge clk) disable iff (rst)
            (!rst_s && ((p_s & e_s & gate_s) == '0)) |-> (!irq_valid_o && irq_cause_o == '0));

        // R9
        cleared_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
            rst_s |-> (!irq_valid_o && irq_cause_o == '0));
    end else begin : g_cmb
        always_comb begin
            // R1
            comb_candidate_chk: assert (!irq_valid_o ||
                (pend_i[irq_cause_o] && ena_i[irq_cause_o]));
        end
    end

endmodule

bind intr_select intr_select_chk #(.NSRC(NSRC), .REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pend_i      (pend_i),
    .ena_i       (ena_i),
    .deleg_i     (deleg_i),
    .priv_i      (priv_i),
    .m_gie_i     (m_gie_i),
    .s_gie_i     (s_gie_i),
    .irq_valid_o (irq_valid_o),
    .irq_cause_o (irq_cause_o)
);

// File: tb/intr_select_test.sv
module intr_select_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pend, ena, deleg;
    logic [1:0]  priv;
    logic        mgie, sgie;
    logic        v_o;
    logic [4:0]  c_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    logic       last_v = 1'b0;
    logic [4:0] last_c = '0;

    always #4 clk = ~clk;

    intr_select uut (
        .clk(clk), .rst(rst), .pend_i(pend), .ena_i(ena), .deleg_i(deleg),
        .priv_i(priv), .m_gie_i(mgie), .s_gie_i(sgie),
        .irq_valid_o(v_o), .irq_cause_o(c_o)
    );

    // Behavioural model written from the requirements.
    task automatic model(output logic ev, output logic [4:0] ec);
        int pv;
        bit men, sen;
        pv  = int'(priv);
        men = (pv < 3) || (pv == 3 && mgie);
        sen = (pv < 1) || (pv == 1 && sgie);
        ev = 1'b0;
        ec = '0;
        for (int i = 0; i < 32; i++) begin
            if (!ev && pend[i] && ena[i] && (deleg[i] ? sen : men)) begin
                ev = 1'b1;
                ec = 5'(i);
            end
        end
    endtask

    task automatic check(string tag, logic ev, logic [4:0] ec);
        compared++;
        if (v_o !== ev || c_o !== ec) begin
            mismatched++;
            $display("FAIL %s: got valid=%0b cause=%0d expected valid=%0b cause=%0d",
                     tag, v_o, c_o, ev, ec);
        end
    endtask

    task automatic step(string tag, logic [31:0] p, logic [31:0] e, logic [31:0] d,
                        logic [1:0] pv, logic m, logic s);
        logic ev;
        logic [4:0] ec;
        @(negedge clk);
        pend = p; ena = e; deleg = d; priv = pv; mgie = m; sgie = s;
        #1;
        // R8: nothing visible before the edge
        check({tag, "/R8"}, last_v, last_c);
        @(posedge clk);
        #2;
        if (rst) begin ev = 1'b0; ec = '0; end
        else model(ev, ec);
        check(tag, ev, ec);
        last_v = ev;
        last_c = ec;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pend = '1; ena = '1; deleg = '0; priv = 2'd0; mgie = 1'b1; sgie = 1'b1;
        @(posedge clk);
        #2;
        // R9: reset clears the outputs even with active candidates
        check("R9", 1'b0, 5'd0);
        step("R9", 32'hFF, 32'hFF, 32'h0, 2'd3, 1'b1, 1'b1);
        rst = 1'b0;
        // R1: pending without enable, enable without pending
        step("R1", 32'h0000_0010, 32'h0000_0000, 32'h0, 2'd3, 1'b1, 1'b0);
        step("R1", 32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b1, 1'b0);
        // R2: machine level at machine privilege depends on m_gie
        step("R2", 32'h0000_0080, 32'h0000_0080, 32'h0, 2'd3, 1'b0, 1'b1);
        step("R2", 32'h0000_0080, 32'h0000_0080, 32'h0, 2'd3, 1'b1, 1'b0);
        step("R2", 32'h0000_0080, 32'h0000_0080, 32'h0, 2'd1, 1'b0, 1'b0);
        // R3: supervisor-routed sources
        step("R3", 32'h0000_0020, 32'h0000_0020, 32'h20, 2'd1, 1'b1, 1'b0);
        step("R3", 32'h0000_0020, 32'h0000_0020, 32'h20, 2'd1, 1'b0, 1'b1);
        step("R3", 32'h0000_0020, 32'h0000_0020, 32'h20, 2'd0, 1'b0, 1'b0);
        // R5: supervisor-routed blocked at machine level even with s_gie
        step("R5", 32'h0000_0008, 32'h0000_0008, 32'h8, 2'd3, 1'b1, 1'b1);
        // R4: undelegated 7 wins over delegated 3 at machine level
        step("R4", 32'h0000_0088, 32'h0000_0088, 32'h8, 2'd3, 1'b1, 1'b1);
        // R6: lowest index wins
        step("R6", 32'h8000_0A00, 32'hFFFF_FFFF, 32'h0, 2'd0, 1'b0, 1'b0);
        step("R6", 32'h8000_0000, 32'h8000_0000, 32'h0, 2'd3, 1'b1, 1'b0);
        step("R6", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 2'd3, 1'b1, 1'b0);
        // R7: nothing allowed
        step("R7", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1'b1, 1'b1);
        // R10: reserved privilege value 2
        step("R10", 32'h0000_0100, 32'h0000_0100, 32'h0, 2'd2, 1'b0, 1'b0);
        step("R10", 32'h0000_0100, 32'h0000_0100, 32'h100, 2'd2, 1'b1, 1'b1);
        // R6 mixed patterns
        for (int k = 0; k < 400; k++) begin
            step("R6", $urandom & $urandom, $urandom, $urandom, 2'($urandom),
                 1'($urandom), 1'($urandom));
        end
        // R9: reset in the middle of activity
        rst = 1'b1;
        step("R9", 32'h1, 32'h1, 32'h0, 2'd0, 1'b0, 1'b0);
        rst = 1'b0;
        step("R1", 32'h4, 32'h4, 32'h0, 2'd0, 1'b0, 1'b0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule